// File: doc/BRIEF.md
# Associative Cell Array with Responder Resolution

This block is a small content-addressable array of processing cells driven by one controller. Each cell stores a record of several 8-bit fields. It also keeps three flags: busy (the cell holds a valid record), active (the cell executes broadcast commands) and responder (the cell matched the last test). Every command is broadcast to all cells in the same cycle, and all cells share one clock. A cell that is busy but not active receives commands and ignores them until it is reactivated. An idle cell, one that is not busy, holds no valid data and may be claimed for a new record.

The controller uses the array in a few ways. It runs masked searches that compare any chosen subset of fields against a broadcast key. It reads back whether any cell responded and which cell is the lowest-numbered responder. It narrows the active set to the responders, or restores every busy cell to active. It claims a free cell, writes a record into it and later frees it. Every cycle the array also produces registered global reductions over the active cells: the OR and AND of one chosen bit of one chosen field, and the maximum and minimum of one chosen field.

Top module: `assoc_array`

## Requirements
- R1: After reset every cell is idle, inactive and not a responder. The outputs are any_resp=0, pick_valid=0, red_valid=0, red_or=0 and red_and=1.
- R2: On SEARCH (cmd_op=1), an active cell becomes a responder exactly when each field i with fmask[i]=1 equals key field i. Field i occupies bits [8*i+7:8*i]. Fields whose mask bit is 0 are not compared, so fmask=0 makes every active cell respond.
- R3: On SEARCH, a cell that is inactive or idle never becomes a responder, whatever its stored contents.
- R4: Every output is registered. It reflects the cell state left by the command issued two clock edges earlier, so any_resp appears one cycle after the search result.
- R5: pick_valid equals any_resp. pick_idx is the lowest-numbered responder.
- R6: On WRITE (cmd_op=5), wr_rec is loaded into the pick-one cell, and that cell becomes busy and active and drops its responder bit. When no responder exists, WRITE changes nothing.
- R7: On FINDFREE (cmd_op=2), exactly the idle cells become responders.
- R8: On FREE (cmd_op=6), the pick-one cell becomes idle, inactive and not a responder, so later searches cannot find it.
- R9: On NARROW (cmd_op=3), the active set becomes the intersection of the active set and the responder set. On RESTORE (cmd_op=4), every busy cell becomes active. cmd_op=0 does nothing.
- R10: red_or and red_and are the OR and AND of bit red_bit of field red_field over the active cells. With no active cell they are 0 and 1.
- R11: red_max and red_min are the largest and smallest value of field red_field over the active cells, with red_valid=1. With no active cell, red_valid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Broadcast command code |
| key | input | 32 | Search key, one 8-bit slice per field |
| fmask | input | 4 | Per-field compare enable for SEARCH |
| wr_rec | input | 32 | Record loaded by WRITE |
| red_field | input | 2 | Field used by the reductions |
| red_bit | input | 3 | Bit within that field used by OR/AND |
| any_resp | output | 1 | At least one responder exists |
| pick_valid | output | 1 | pick_idx is meaningful |
| pick_idx | output | 4 | Lowest-numbered responder |
| red_or | output | 1 | OR of the chosen bit over active cells |
| red_and | output | 1 | AND of the chosen bit over active cells |
| red_valid | output | 1 | At least one active cell exists |
| red_max | output | 8 | Maximum of the chosen field over active cells |
| red_min | output | 8 | Minimum of the chosen field over active cells |

## Verification
The bench fills cells in order through FINDFREE and WRITE, and checks that each write lands in the next free slot. A resolver that ignored priority would scatter the records, and a write that kept its responder bit would overwrite the same cell again. Searches run with partial masks, the empty mask and keys that match nothing, and they also target cells that have been narrowed out or freed. A design that let inactive or idle cells respond would report a responder there. Reductions are checked after narrowing, after freeing and with no active cell at all, where a wrong identity value or a missing valid flag shows up directly. A WRITE with no responder must leave the free-cell order unchanged.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_SEARCH   = 3'd1,
    OP_FINDFREE = 3'd2,
    OP_NARROW   = 3'd3,
    OP_RESTORE  = 3'd4,
    OP_WRITE    = 3'd5,
    OP_FREE     = 3'd6
  } op_e;
endpackage

// File: rtl/assoc_cell.sv
module assoc_cell
  import assoc_pkg::*;
#(
  parameter int NF = 4,
  parameter int FW = 8,
  localparam int RW = NF * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  input  logic [RW-1:0] key,
  input  logic [NF-1:0] fmask,
  input  logic [RW-1:0] wr_rec,
  input  logic          sel,
  output logic [RW-1:0] rec,
  output logic          busy,
  output logic          active,
  output logic          resp
);
  logic [NF-1:0] fhit;
  logic          match;

  always_comb begin
    for (int f = 0; f < NF; f++)
      fhit[f] = !fmask[f] || (rec[f*FW +: FW] == key[f*FW +: FW]);
    match = &fhit;
  end

  always_ff @(posedge clk) begin
    if (op == OP_WRITE && sel) rec <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      active <= 1'b0;
      resp   <= 1'b0;
    end else begin
      case (op)
        OP_SEARCH:   resp   <= active && match;
        OP_FINDFREE: resp   <= !busy;
        OP_NARROW:   active <= active && resp;
        OP_RESTORE:  active <= busy;
        OP_WRITE: if (sel) begin
          busy   <= 1'b1;
          active <= 1'b1;
          resp   <= 1'b0;
        end
        OP_FREE: if (sel) begin
          busy   <= 1'b0;
          active <= 1'b0;
          resp   <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/assoc_resolver.sv
module assoc_resolver #(
  parameter int NC = 16,
  localparam int LW = $clog2(NC)
) (
  input  logic [NC-1:0] resp,
  output logic          any,
  output logic [LW-1:0] idx,
  output logic [NC-1:0] onehot
);
  always_comb begin
    any    = |resp;
    idx    = '0;
    onehot = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      if (resp[c]) idx = LW'(c);
    end
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/assoc_reduce.sv
module assoc_reduce #(
  parameter int NC = 16,
  parameter int NF = 4,
  parameter int FW = 8,
  localparam int FSW = (NF > 1) ? $clog2(NF) : 1,
  localparam int BSW = (FW > 1) ? $clog2(FW) : 1,
  localparam int RW  = NF * FW
) (
  input  logic [NC*RW-1:0] recs,
  input  logic [NC-1:0]    active,
  input  logic [FSW-1:0]   fsel,
  input  logic [BSW-1:0]   bsel,
  output logic             r_or,
  output logic             r_and,
  output logic             r_valid,
  output logic [FW-1:0]    r_max,
  output logic [FW-1:0]    r_min
);
  always_comb begin
    logic [FW-1:0] v;
    r_or    = 1'b0;
    r_and   = 1'b1;
    r_valid = 1'b0;
    r_max   = '0;
    r_min   = '1;
    for (int c = 0; c < NC; c++) begin
      v = recs[c*RW + int'(fsel)*FW +: FW];
      if (active[c]) begin
        r_valid = 1'b1;
        r_or    = r_or | v[bsel];
        r_and   = r_and & v[bsel];
        if (v > r_max) r_max = v;
        if (v < r_min) r_min = v;
      end
    end
  end
endmodule

// File: rtl/assoc_array.sv
module assoc_array
  import assoc_pkg::*;
#(
  parameter int NC = 16,
  parameter int NF = 4,
  parameter int FW = 8,
  localparam int LW  = $clog2(NC),
  localparam int FSW = (NF > 1) ? $clog2(NF) : 1,
  localparam int BSW = (FW > 1) ? $clog2(FW) : 1,
  localparam int RW  = NF * FW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     cmd_op,
  input  logic [RW-1:0]  key,
  input  logic [NF-1:0]  fmask,
  input  logic [RW-1:0]  wr_rec,
  input  logic [FSW-1:0] red_field,
  input  logic [BSW-1:0] red_bit,
  output logic           any_resp,
  output logic           pick_valid,
  output logic [LW-1:0]  pick_idx,
  output logic           red_or,
  output logic           red_and,
  output logic           red_valid,
  output logic [FW-1:0]  red_max,
  output logic [FW-1:0]  red_min
);
  op_e              op;
  logic [NC*RW-1:0] recs;
  logic [NC-1:0]    busy_v, active_v, resp_v, sel_v;
  logic             any_c;
  logic [LW-1:0]    idx_c;
  logic             or_c, and_c, valid_c;
  logic [FW-1:0]    max_c, min_c;

  assign op = op_e'(cmd_op);

  for (genvar c = 0; c < NC; c++) begin : g_cell
    assoc_cell #(.NF(NF), .FW(FW)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .key    (key),
      .fmask  (fmask),
      .wr_rec (wr_rec),
      .sel    (sel_v[c]),
      .rec    (recs[c*RW +: RW]),
      .busy   (busy_v[c]),
      .active (active_v[c]),
      .resp   (resp_v[c])
    );
  end

  assoc_resolver #(.NC(NC)) u_res (
    .resp   (resp_v),
    .any    (any_c),
    .idx    (idx_c),
    .onehot (sel_v)
  );

  assoc_reduce #(.NC(NC), .NF(NF), .FW(FW)) u_red (
    .recs    (recs),
    .active  (active_v),
    .fsel    (red_field),
    .bsel    (red_bit),
    .r_or    (or_c),
    .r_and   (and_c),
    .r_valid (valid_c),
    .r_max   (max_c),
    .r_min   (min_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      any_resp   <= 1'b0;
      pick_valid <= 1'b0;
      pick_idx   <= '0;
      red_or     <= 1'b0;
      red_and    <= 1'b1;
      red_valid  <= 1'b0;
      red_max    <= '0;
      red_min    <= '0;
    end else begin
      any_resp   <= any_c;
      pick_valid <= any_c;
      pick_idx   <= idx_c;
      red_or     <= or_c;
      red_and    <= and_c;
      red_valid  <= valid_c;
      red_max    <= max_c;
      red_min    <= min_c;
    end
  end
endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
  parameter int NC = 16,
  parameter int FW = 8,
  localparam int LW = $clog2(NC)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd_op,
  input logic [NC-1:0] busy_v,
  input logic [NC-1:0] active_v,
  input logic [NC-1:0] resp_v,
  input logic          any_resp,
  input logic          pick_valid,
  input logic [LW-1:0] pick_idx,
  input logic          red_valid,
  input logic [FW-1:0] red_max,
  input logic [FW-1:0] red_min
);
  logic [NC-1:0] resp_q;
  logic [NC-1:0] below;

  always_ff @(posedge clk) begin
    if (rst) resp_q <= '0;
    else     resp_q <= resp_v;
  end

  always_comb begin
    below = '0;
    for (int c = 0; c < NC; c++) below[c] = (LW'(c) < pick_idx);
  end

  AST_ACTIVE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (active_v & ~busy_v) == '0);  // R9
  AST_SEARCH_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd1) |=> ((resp_v & ~active_v) == '0));  // R3
  AST_ANY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    any_resp == (|resp_q));  // R4
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> (resp_q[pick_idx] && ((resp_q & below) == '0)));  // R5
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    red_valid |-> (red_min <= red_max));  // R11
endmodule

bind assoc_array assoc_array_chk #(.NC(NC), .FW(FW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_op     (cmd_op),
  .busy_v     (busy_v),
  .active_v   (active_v),
  .resp_v     (resp_v),
  .any_resp   (any_resp),
  .pick_valid (pick_valid),
  .pick_idx   (pick_idx),
  .red_valid  (red_valid),
  .red_max    (red_max),
  .red_min    (red_min)
);

// File: tb/sim_assoc_array.sv
module sim_assoc_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] key = '0;
  logic [3:0]  fmask = '0;
  logic [31:0] wr_rec = '0;
  logic [1:0]  red_field = '0;
  logic [2:0]  red_bit = '0;
  logic        any_resp, pick_valid, red_or, red_and, red_valid;
  logic [3:0]  pick_idx;
  logic [7:0]  red_max, red_min;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  assoc_array u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .key(key), .fmask(fmask),
    .wr_rec(wr_rec), .red_field(red_field), .red_bit(red_bit),
    .any_resp(any_resp), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .red_or(red_or), .red_and(red_and), .red_valid(red_valid),
    .red_max(red_max), .red_min(red_min)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // issue one command at a falling edge, then let outputs settle (two edges)
  task automatic cmd(logic [2:0] op, logic [31:0] k = '0, logic [3:0] m = '0,
                     logic [31:0] r = '0);
    cmd_op = op; key = k; fmask = m; wr_rec = r;
    @(negedge clk);
    cmd_op = 3'd0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] rec(int f0, int f1, int f2, int f3);
    return {8'(f3), 8'(f2), 8'(f1), 8'(f0)};
  endfunction

  task automatic t_reset();
    chk("R1 any", any_resp, 0);
    chk("R1 pick_valid", pick_valid, 0);
    chk("R1 red_valid", red_valid, 0);
    chk("R1 red_or", red_or, 0);
    chk("R1 red_and", red_and, 1);
  endtask

  task automatic t_fill();
    cmd(3'd2);
    chk("R7 findfree pick", pick_idx, 0);
    chk("R7 findfree any", any_resp, 1);
    cmd(3'd5, '0, '0, rec(1, 1, 50, 94));
    chk("R6 next free after write", pick_idx, 1);
    cmd(3'd5, '0, '0, rec(2, 0, 30, 96));
    cmd(3'd5, '0, '0, rec(3, 1, 70, 98));
    cmd(3'd5, '0, '0, rec(1, 1, 20, 97));
    chk("R6 pick after four writes", pick_idx, 4);
  endtask

  task automatic t_reduce_all();
    red_field = 2'd2; red_bit = 3'd0;
    @(negedge clk);
    chk("R11 max", red_max, 70);
    chk("R11 min", red_min, 20);
    chk("R11 valid", red_valid, 1);
    red_field = 2'd1;
    @(negedge clk);
    chk("R10 or lot", red_or, 1);
    chk("R10 and lot", red_and, 0);
  endtask

  task automatic t_search();
    cmd(3'd1, rec(1, 1, 0, 0), 4'b0011);
    chk("R2 two-field any", any_resp, 1);
    chk("R5 lowest pick", pick_idx, 0);
    cmd(3'd1, rec(0, 0, 0, 97), 4'b1000);
    chk("R2 year field pick", pick_idx, 3);
    cmd(3'd1, rec(2, 1, 0, 0), 4'b0011);
    chk("R2 no match any", any_resp, 0);
    chk("R5 no match valid", pick_valid, 0);
    cmd(3'd1, rec(9, 9, 9, 9), 4'b0000);
    chk("R2 empty mask any", any_resp, 1);
    chk("R2 empty mask pick", pick_idx, 0);
  endtask

  task automatic t_narrow();
    cmd(3'd1, rec(1, 1, 0, 0), 4'b0011);
    cmd(3'd3);
    red_field = 2'd2;
    @(negedge clk);
    chk("R9 narrow max", red_max, 50);
    chk("R9 narrow min", red_min, 20);
    red_field = 2'd1;
    @(negedge clk);
    chk("R10 and over narrowed", red_and, 1);
    cmd(3'd1, rec(2, 0, 0, 0), 4'b0001);
    chk("R3 inactive cell ignored", any_resp, 0);
    cmd(3'd4);
    cmd(3'd1, rec(2, 0, 0, 0), 4'b0001);
    chk("R9 restore pick", pick_idx, 1);
  endtask

  task automatic t_free();
    cmd(3'd1, rec(0, 0, 0, 97), 4'b1000);
    cmd(3'd6);
    red_field = 2'd2;
    @(negedge clk);
    chk("R8 free min", red_min, 30);
    chk("R8 free max", red_max, 70);
    cmd(3'd1, rec(0, 0, 0, 97), 4'b1000);
    chk("R3 idle cell ignored", any_resp, 0);
    cmd(3'd2);
    chk("R7 freed cell first", pick_idx, 3);
    cmd(3'd5, '0, '0, rec(5, 0, 99, 1));
    cmd(3'd1, rec(5, 0, 0, 0), 4'b0001);
    chk("R6 rewrite pick", pick_idx, 3);
    chk("R6 rewrite max", red_max, 99);
    cmd(3'd1, rec(77, 0, 0, 0), 4'b0001);
    cmd(3'd5, '0, '0, rec(200, 0, 250, 0));
    chk("R6 no-responder write max", red_max, 99);
    cmd(3'd2);
    chk("R6 no-responder write free order", pick_idx, 4);
  endtask

  task automatic t_empty();
    cmd(3'd1, rec(77, 0, 0, 0), 4'b0001);
    cmd(3'd3);
    chk("R11 empty valid", red_valid, 0);
    chk("R10 empty or", red_or, 0);
    chk("R10 empty and", red_and, 1);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_reduce_all();
        t_search();
        t_narrow();
        t_free();
        t_empty();
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got 0 expected 1");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule